// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervision counter that must be serviced by software at the right moment. It counts ticks of a slow clock enable. If software does not service it in time, it raises a one-cycle reset request. Software services it by writing a fixed key byte through an 8-bit write port. A service write is accepted only while a window is open, and that window always lies at the end of the current period. A write that comes too early, or that carries the wrong byte, is treated as a fault and also raises the reset request.

The period, the window size and the sleep policy are static configuration pins. The block captures them on every clock edge while `rst_n` is low and ignores them after that. With the keep-running option cleared, the count freezes and keeps its value while the device is halted, stopped, or has its slow oscillator stopped. The count then resumes from that value on wake-up. With the option set, those inputs have no effect.

Top module: `wwdt_core`

## Requirements
- R1: With period select N (0 to 7), the reset pulse follows the 2^(10+N)-th counted tick after reset or after a restart, and counting then starts again from zero.
- R2: `wdt_rst_o` is high for exactly one clock cycle, in the cycle after the clock edge that consumed the tick that caused it.
- R3: With P the period, the window is open when the count (ticks since the last restart) is at least 3P/4 for window select 00, P/2 for 01, P/4 for 10, and 0 for 11.
- R4: A write of 0xAC while the window is open clears the count, so the next pulse comes only after a full period of further ticks.
- R5: A write while the window is closed, or a write of any byte other than 0xAC, raises the pulse on the next tick (not before) and restarts the count from zero.
- R6: `cfg_error_o` is 1 exactly when the captured configuration has period select 000 and window select 00. Configuration pins are captured only while `rst_n` is low, and changes after reset have no effect.
- R7: With keep-running 0, ticks arriving while `halt_i` or `stop_i` is high are not counted, and the count resumes from its held value afterwards.
- R8: With keep-running 0, ticks arriving while `osc_stop_i` is high are not counted, and the count is not cleared.
- R9: With keep-running 1, `halt_i`, `stop_i` and `osc_stop_i` have no effect on counting.
- R10: After reset `wdt_rst_o` is low and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; also captures the configuration pins |
| tick_en | input | 1 | One-cycle enable standing in for a slow-clock edge |
| cfg_period_sel | input | 3 | Period exponent offset N, period 2^(10+N) ticks |
| cfg_window_sel | input | 2 | Window size select |
| cfg_keep_run | input | 1 | 1 = keep counting through sleep and oscillator stop |
| halt_i | input | 1 | Device halted |
| stop_i | input | 1 | Device stopped |
| osc_stop_i | input | 1 | Software request to stop the slow oscillator |
| wr_en | input | 1 | Service write strobe |
| wr_data | input | 8 | Service write byte |
| wdt_rst_o | output | 1 | One-cycle reset request |
| cfg_error_o | output | 1 | Illegal configuration flag |

## Verification
The hardest situation to reach is a count frozen partway through a period and then resumed. Showing that it resumed from its held value means telling "paused" apart from "silently cleared", and the ports alone cannot show that. The bench therefore spends an exact number of ticks before sleep, feeds thousands of ticks during sleep, and then spends exactly the remainder. It expects no pulse until the final tick, which lands on the period boundary. The window edges are reached in the same way: the bench puts the count exactly one tick before, and exactly at, each threshold before it writes the key.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  typedef enum logic [1:0] {
    WIN_LAST_QUARTER = 2'b00,
    WIN_LAST_HALF    = 2'b01,
    WIN_LAST_3Q      = 2'b10,
    WIN_ALWAYS       = 2'b11
  } win_sel_e;
endpackage

// File: rtl/wwdt_cfg_latch.sv
module wwdt_cfg_latch #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       win_i,
  input  logic             keep_i,
  output logic [SEL_W-1:0] sel_q,
  output logic [1:0]       win_q,
  output logic             keep_q,
  output logic             err_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= sel_i;
      win_q  <= win_i;
      keep_q <= keep_i;
    end
  end

  assign err_o = (sel_q == '0) && (win_q == 2'b00);
endmodule

// File: rtl/wwdt_limits.sv
module wwdt_limits
  import wwdt_pkg::*;
#(
  parameter int CNT_W    = 17,
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 10
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       win_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] last_o,
  output logic             open_o
);
  localparam logic [CNT_W-1:0] ALL1 = '1;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] quarter;
  logic [CNT_W-1:0] thr;

  always_comb begin
    last_o  = ALL1 >> (CNT_W - BASE_EXP - int'(sel_i));
    quarter = (last_o >> 2) + ONE;
    unique case (win_sel_e'(win_i))
      WIN_LAST_QUARTER: thr = quarter + (quarter << 1);
      WIN_LAST_HALF:    thr = quarter << 1;
      WIN_LAST_3Q:      thr = quarter;
      default:          thr = '0;
    endcase
    open_o = (cnt_i >= thr);
  end
endmodule

// File: rtl/wwdt_key_gate.sv
module wwdt_key_gate #(
  parameter int          KEY_W = 8,
  parameter logic [7:0]  KEY   = 8'hAC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] wr_data_i,
  input  logic             open_i,
  output logic             restart_o,
  output logic             fire_o
);
  logic key_ok;
  logic bad_wr;
  logic pend_q;

  assign key_ok    = (wr_data_i == KEY_W'(KEY));
  assign restart_o = wr_en_i && open_i && key_ok;
  assign bad_wr    = wr_en_i && !(open_i && key_ok);
  assign fire_o    = tick_i && pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q && !fire_o) || bad_wr;
  end
endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic step;
  assign step  = tick_i && run_i && !restart_i && !fire_i;
  assign ovf_o = step && (cnt_o == last_i);

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_o <= '0;
    else if (restart_i || fire_i) cnt_o <= '0;
    else if (step)               cnt_o <= (cnt_o == last_i) ? '0 : cnt_o + 1'b1;
  end
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core #(
  parameter int         CNT_W    = 17,
  parameter int         SEL_W    = 3,
  parameter int         BASE_EXP = 10,
  parameter int         KEY_W    = 8,
  parameter logic [7:0] KEY      = 8'hAC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] cfg_period_sel,
  input  logic [1:0]       cfg_window_sel,
  input  logic             cfg_keep_run,
  input  logic             halt_i,
  input  logic             stop_i,
  input  logic             osc_stop_i,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_data,
  output logic             wdt_rst_o,
  output logic             cfg_error_o
);
  logic [SEL_W-1:0] sel_q;
  logic [1:0]       win_q;
  logic             keep_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             win_open;
  logic             restart_ok;
  logic             fire;
  logic             ovf;
  logic             run;

  wwdt_cfg_latch #(.SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .sel_i(cfg_period_sel), .win_i(cfg_window_sel),
    .keep_i(cfg_keep_run), .sel_q(sel_q), .win_q(win_q), .keep_q(keep_q),
    .err_o(cfg_error_o)
  );

  wwdt_limits #(.CNT_W(CNT_W), .SEL_W(SEL_W), .BASE_EXP(BASE_EXP)) u_lim (
    .sel_i(sel_q), .win_i(win_q), .cnt_i(cnt), .last_o(last), .open_o(win_open)
  );

  wwdt_key_gate #(.KEY_W(KEY_W), .KEY(KEY)) u_key (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .open_i(win_open), .restart_o(restart_ok), .fire_o(fire)
  );

  assign run = keep_q || !(halt_i || stop_i || osc_stop_i);

  wwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .run_i(run),
    .restart_i(restart_ok), .fire_i(fire), .last_i(last), .cnt_o(cnt), .ovf_o(ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wdt_rst_o <= 1'b0;
    else        wdt_rst_o <= ovf || fire;
  end
endmodule

// File: rtl/wwdt_core_chk.sv
module wwdt_core_chk #(
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             halt_i,
  input logic             stop_i,
  input logic             osc_stop_i,
  input logic             keep_q,
  input logic             restart_ok,
  input logic             fire,
  input logic [CNT_W-1:0] cnt,
  input logic             wdt_rst_o,
  input logic             cfg_error_o
);
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |=> !wdt_rst_o);

  p_pulse_from_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> $past(tick_en));

  p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_ok |=> (cnt == '0));

  p_bad_write_pulses_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> wdt_rst_o);

  p_sleep_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!keep_q && (halt_i || stop_i) && !restart_ok && !fire) |=> $stable(cnt));

  p_osc_stop_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!keep_q && osc_stop_i && !restart_ok && !fire) |=> $stable(cnt));

  p_cfg_flag_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(cfg_error_o));
endmodule

bind wwdt_core wwdt_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt_i(halt_i), .stop_i(stop_i),
  .osc_stop_i(osc_stop_i), .keep_q(keep_q), .restart_ok(restart_ok), .fire(fire),
  .cnt(cnt), .wdt_rst_o(wdt_rst_o), .cfg_error_o(cfg_error_o)
);

// File: tb/wwdt_core_tb.sv
module wwdt_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [2:0] cfg_period_sel = '0;
  logic [1:0] cfg_window_sel = '0;
  logic       cfg_keep_run = 1'b0;
  logic       halt_i = 1'b0, stop_i = 1'b0, osc_stop_i = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wdt_rst_o, cfg_error_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wwdt_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_period_sel(cfg_period_sel),
    .cfg_window_sel(cfg_window_sel), .cfg_keep_run(cfg_keep_run), .halt_i(halt_i),
    .stop_i(stop_i), .osc_stop_i(osc_stop_i), .wr_en(wr_en), .wr_data(wr_data),
    .wdt_rst_o(wdt_rst_o), .cfg_error_o(cfg_error_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] sel, input logic [1:0] win, input logic keep);
    @(negedge clk);
    cfg_period_sel = sel; cfg_window_sel = win; cfg_keep_run = keep;
    halt_i = 0; stop_i = 0; osc_stop_i = 0; wr_en = 0; tick_en = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Each tick: one cycle with tick high, one idle; both output cycles are sampled.
  task automatic do_ticks(input int n, output int pulses, output int first);
    pulses = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      if (wdt_rst_o) begin pulses++; if (first == 0) first = i; end
      @(negedge clk);
      if (wdt_rst_o) pulses++;
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_state();
    int p, f;
    do_reset(3'd0, 2'b00, 1'b0);
    check("R10 reset output low", wdt_rst_o, 0);
    check("R6 cfg_error for 000/00", cfg_error_o, 1);
    do_ticks(1023, p, f);
    check("R10 count starts at zero", p, 0);
  endtask

  task automatic t_overflow();
    int p, f;
    do_reset(3'd0, 2'b01, 1'b0);
    check("R6 cfg_error clear for legal config", cfg_error_o, 0);
    do_ticks(1024, p, f);
    check("R1 period 2^10 pulse tick", f, 1024);
    check("R2 single-cycle pulse", p, 1);
    do_ticks(1024, p, f);
    check("R1 restart after overflow", f, 1024);
    do_reset(3'd2, 2'b11, 1'b0);
    cfg_period_sel = 3'd0; cfg_window_sel = 2'b00;
    repeat (2) @(negedge clk);
    check("R6 pins ignored after reset", cfg_error_o, 0);
    do_ticks(4096, p, f);
    check("R1 R6 period 2^12 pulse tick", f, 4096);
    check("R2 one pulse in period 2^12", p, 1);
  endtask

  task automatic t_restart_ok();
    int p, f;
    do_reset(3'd1, 2'b00, 1'b0);
    do_ticks(1536, p, f);
    do_write(8'hAC);
    @(negedge clk);
    check("R4 no pulse after key write", wdt_rst_o, 0);
    do_ticks(2047, p, f);
    check("R4 full period after restart", p, 0);
    do_ticks(1, p, f);
    check("R4 pulse at end of new period", p, 1);
  endtask

  task automatic probe(input logic [1:0] win, input int k, input bit ok, input string req);
    int p, f;
    do_reset(3'd1, win, 1'b0);
    do_ticks(k, p, f);
    do_write(8'hAC);
    do_ticks(1, p, f);
    check(req, p, ok ? 0 : 1);
  endtask

  task automatic t_window_edges();
    probe(2'b00, 1535, 1'b0, "R3 quarter window closed at 1535");
    probe(2'b00, 1536, 1'b1, "R3 quarter window open at 1536");
    probe(2'b01, 1023, 1'b0, "R3 half window closed at 1023");
    probe(2'b01, 1024, 1'b1, "R3 half window open at 1024");
    probe(2'b10, 511,  1'b0, "R3 3q window closed at 511");
    probe(2'b10, 512,  1'b1, "R3 3q window open at 512");
    probe(2'b11, 0,    1'b1, "R3 full window open at 0");
  endtask

  task automatic t_bad_write();
    int p, f;
    do_reset(3'd0, 2'b11, 1'b0);
    do_ticks(10, p, f);
    do_write(8'h55);
    p = 0;
    repeat (5) begin @(negedge clk); if (wdt_rst_o) p++; end
    check("R5 no pulse before next tick", p, 0);
    do_ticks(1, p, f);
    check("R5 wrong key pulses on next tick", p, 1);
    do_ticks(1023, p, f);
    check("R5 count restarted after fault", p, 0);
    do_ticks(1, p, f);
    check("R5 overflow after fault restart", p, 1);
  endtask

  task automatic t_sleep();
    int p, f;
    do_reset(3'd0, 2'b01, 1'b0);
    do_ticks(500, p, f);
    halt_i = 1'b1;
    do_ticks(3000, p, f);
    check("R7 frozen in halt", p, 0);
    halt_i = 1'b0;
    do_ticks(523, p, f);
    check("R7 resumes after halt", p, 0);
    do_ticks(1, p, f);
    check("R7 count kept through halt", p, 1);
    do_ticks(300, p, f);
    stop_i = 1'b1;
    do_ticks(2000, p, f);
    check("R7 frozen in stop", p, 0);
    stop_i = 1'b0;
    do_ticks(723, p, f);
    do_ticks(1, p, f);
    check("R7 count kept through stop", f, 1);
  endtask

  task automatic t_osc_stop();
    int p, f;
    do_reset(3'd0, 2'b01, 1'b0);
    do_ticks(200, p, f);
    osc_stop_i = 1'b1;
    do_ticks(1500, p, f);
    check("R8 frozen with oscillator stopped", p, 0);
    osc_stop_i = 1'b0;
    do_ticks(823, p, f);
    check("R8 not cleared", p, 0);
    do_ticks(1, p, f);
    check("R8 pulse at held remainder", p, 1);
  endtask

  task automatic t_keep_run();
    int p, f;
    do_reset(3'd0, 2'b01, 1'b1);
    halt_i = 1'b1; stop_i = 1'b1; osc_stop_i = 1'b1;
    do_ticks(1024, p, f);
    check("R9 keeps counting in sleep", f, 1024);
    check("R9 one pulse", p, 1);
    halt_i = 1'b0; stop_i = 1'b0; osc_stop_i = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_overflow();
    t_restart_ok();
    t_window_edges();
    t_bad_write();
    t_sleep();
    t_osc_stop();
    t_keep_run();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule